// File: doc/BRIEF.md
# Memory-Mapped Parallel I/O Port

This block is a small parallel I/O peripheral hanging off a processor's 8-bit data bus and 16-bit address bus. It takes two consecutive addresses. The lower one, the base address, is an output register. A write cycle to it captures the data bus into a bank of flip-flops whose outputs drive the peripheral pins. Those pins keep that value until the next write to the same address. The upper one, base+1, is a pass-through input. A read cycle to it places the live state of the input pins on the data bus. The input value is never stored.

Two separate address comparisons select the write function and the read function. The active-high write strobe qualifies one and the active-high read strobe qualifies the other. An active-high enable gates both of them. The shared data bus is split into an inbound byte, an outbound byte and an output-enable. The output-enable is high only while the port answers one of its own read cycles, so a board-level tri-state driver can be built from these three signals.

Top module: `pio_port`

## Requirements
- R1: While reset is asserted and after it is released, `pinsOut` is 0x00 until the first qualifying write.
- R2: When `en`, `wrStb` and `addr == BASE_ADDR` are all high at a rising clock edge, `pinsOut` takes the value of `dataIn` sampled at that edge, and the change is visible after that edge.
- R3: At an edge without a qualifying write, `pinsOut` keeps its previous value.
- R4: When `en`, `rdStb` and `addr == BASE_ADDR+1` are all high, `dataOe` is 1 and `dataOut` equals `pinsIn` in the same cycle, with no clock edge in the path.
- R5: In every other case `dataOe` is 0 and `dataOut` is 0x00. A read of the output address (base) does not drive the bus.
- R6: When `en` is 0, the port neither loads `pinsOut` nor asserts `dataOe`, whatever the strobes and address are.
- R7: The input value is not stored. During a read, `dataOut` follows changes on `pinsIn` within the same cycle, and a read leaves `pinsOut` unchanged.
- R8: All 16 address bits are compared. An address that differs from the selected address in any single bit selects nothing.
- R9: A write cycle to base+1 does not change `pinsOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; the output register loads on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Active-high enable for the whole port |
| rdStb | input | 1 | Active-high read strobe |
| wrStb | input | 1 | Active-high write strobe |
| addr | input | 16 | Bus address |
| dataIn | input | 8 | Data bus value driven by the processor |
| dataOut | output | 8 | Value the port places on the data bus, 0x00 when not driving |
| dataOe | output | 1 | High while the port drives the data bus |
| pinsIn | input | 8 | Peripheral input pins |
| pinsOut | output | 8 | Peripheral output pins from the output register |

## Verification
The bench builds the port at its default widths, 16 address bits and 8 data bits, with a base address of 0x4C20. At these widths the whole 65,536-entry address space can be read cycle by cycle. This shows that the output-enable rises at exactly one address and that the returned byte always equals the pins. Write cycles sweep a 512-address window around the base and every single-bit neighbour of the base. This shows that only the base address loads the register. Further directed cycles cover the enable, strobe combinations, writes to base+1 and input changes during a read.

// File: rtl/pio_pkg.sv
package pio_pkg;

  // Strobes passed from the address decoder to the register datapath
  typedef struct packed {
    logic wrLoad;   // load the output register this edge
    logic rdDrive;  // drive the input pins onto the data bus
  } pio_strobe_t;

endpackage

// File: rtl/pio_decode.sv
module pio_decode
  import pio_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h4C20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              en,
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] addr,
  output pio_strobe_t       stb
);

  localparam logic [ADDR_W-1:0] OUT_ADDR = BASE_ADDR;
  localparam logic [ADDR_W-1:0] IN_ADDR  = BASE_ADDR + ADDR_W'(1);

  logic [ADDR_W-1:0] outBitHit;
  logic [ADDR_W-1:0] inBitHit;
  logic              outHit;
  logic              inHit;

  // Per-bit comparators: every address bit takes part in the match
  for (genvar b = 0; b < ADDR_W; b++) begin : g_bitCmp
    assign outBitHit[b] = (addr[b] == OUT_ADDR[b]);
    assign inBitHit[b]  = (addr[b] == IN_ADDR[b]);
  end

  assign outHit = &outBitHit;
  assign inHit  = &inBitHit;

  always_comb begin
    stb.wrLoad  = en & wrStb & outHit;
    stb.rdDrive = en & rdStb & inHit;
  end

  // R8/R9: two distinct addresses can never both be selected
  assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrLoad, stb.rdDrive}));

  // R6: a disabled port raises no strobe
  assert_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    !en |-> (stb == '0));

endmodule

// File: rtl/pio_regs.sv
module pio_regs
  import pio_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  pio_strobe_t       stb,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [DATA_W-1:0] pinsIn,
  output logic [DATA_W-1:0] pinsOut,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);

  logic [DATA_W-1:0] outReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           outReg <= RESET_VAL;
    else if (stb.wrLoad) outReg <= dataIn;
  end

  assign pinsOut = outReg;

  // Input side: pure buffer, no storage
  always_comb begin
    dataOe  = stb.rdDrive;
    dataOut = stb.rdDrive ? pinsIn : '0;
  end

  // R2: a selected write lands on the pins after the edge
  assert_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrLoad |=> (pinsOut == $past(dataIn)));

  // R3: without a selected write the pins hold
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrLoad |=> $stable(pinsOut));

  // R5: an idle port presents zero on its outbound byte
  assert_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    !dataOe |-> (dataOut == '0));

endmodule

// File: rtl/pio_port.sv
module pio_port
  import pio_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h4C20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              en,
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  input  logic [DATA_W-1:0] pinsIn,
  output logic [DATA_W-1:0] pinsOut
);

  pio_strobe_t stb;

  pio_decode #(
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR)
  ) uDecode (
    .clk  (clk),
    .rstN (rstN),
    .en   (en),
    .rdStb(rdStb),
    .wrStb(wrStb),
    .addr (addr),
    .stb  (stb)
  );

  pio_regs #(
    .DATA_W   (DATA_W),
    .RESET_VAL('0)
  ) uRegs (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .dataIn (dataIn),
    .pinsIn (pinsIn),
    .pinsOut(pinsOut),
    .dataOut(dataOut),
    .dataOe (dataOe)
  );

  // R4: whenever the port drives, it drives the live input pins
  assert_passthru_R4: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> (dataOut == pinsIn));

endmodule

// File: tb/sim_pio_port.sv
`timescale 1ns/1ps
module sim_pio_port;

  localparam logic [15:0] BASE = 16'h4C20;
  localparam logic [15:0] INA  = BASE + 16'd1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        en = 1'b0, rdStb = 1'b0, wrStb = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  dataIn = '0, pinsIn = '0;
  logic [7:0]  dataOut, pinsOut;
  logic        dataOe;

  int testsRun = 0;
  int testsFailed = 0;
  logic [7:0] expOut = 8'h00;

  always #2.5 clk = ~clk;

  pio_port #(.ADDR_W(16), .DATA_W(8), .BASE_ADDR(BASE)) u0 (
    .clk(clk), .rstN(rstN), .en(en), .rdStb(rdStb), .wrStb(wrStb),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .pinsIn(pinsIn), .pinsOut(pinsOut)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // One bus cycle driven at the falling edge; pins checked after the rising edge
  task automatic busWrite(input logic e, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    en = e; wrStb = 1'b1; rdStb = 1'b0; addr = a; dataIn = d;
    @(negedge clk);
    wrStb = 1'b0; en = 1'b0;
  endtask

  task automatic checkPins(input string req);
    #1;
    chk(pinsOut == expOut, req, {8'h0, pinsOut}, {8'h0, expOut});
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    testsRun++; testsFailed++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(pinsOut == 8'h00, "R1 in reset", {8'h0, pinsOut}, 16'h0);
    rstN = 1'b1;
    @(negedge clk); #1;
    chk(pinsOut == 8'h00, "R1 after reset", {8'h0, pinsOut}, 16'h0);
    chk(dataOe == 1'b0, "R5 idle oe", {15'h0, dataOe}, 16'h0);

    // R2: basic writes
    busWrite(1'b1, BASE, 8'hA7); expOut = 8'hA7; checkPins("R2 write A7");
    busWrite(1'b1, BASE, 8'h3C); expOut = 8'h3C; checkPins("R2 write 3C");

    // R3: idle cycles hold
    repeat (4) @(negedge clk);
    checkPins("R3 hold idle");

    // R6: enable low blocks write
    busWrite(1'b0, BASE, 8'hFF); checkPins("R6 write while disabled");

    // R9: write to base+1 ignored
    busWrite(1'b1, INA, 8'h11); checkPins("R9 write to input addr");

    // R8: single-bit neighbours of base
    for (int k = 0; k < 16; k++) begin
      busWrite(1'b1, BASE ^ (16'd1 << k), 8'(k) ^ 8'hC3);
      checkPins("R8 neighbour write");
    end

    // R2/R3: window sweep around base
    for (int i = 0; i < 512; i++) begin
      logic [15:0] a;
      a = BASE - 16'd256 + 16'(i);
      busWrite(1'b1, a, 8'(i) ^ 8'hA5);
      if (a == BASE) expOut = 8'(i) ^ 8'hA5;
      checkPins("R3 window write");
    end

    // R4/R5/R8: exhaustive read sweep
    for (int i = 0; i < 65536; i++) begin
      logic expOe;
      logic [7:0] pv;
      @(negedge clk);
      addr = 16'(i); pv = 8'(i) ^ 8'h5A; pinsIn = pv;
      en = 1'b1; rdStb = 1'b1; wrStb = 1'b0;
      #1;
      expOe = (16'(i) == INA);
      chk(dataOe == expOe, "R5 read sweep oe", {15'h0, dataOe}, {15'h0, expOe});
      chk(dataOut == (expOe ? pv : 8'h00), "R4 read sweep data",
          {8'h0, dataOut}, {8'h0, (expOe ? pv : 8'h00)});
    end
    @(negedge clk); rdStb = 1'b0; en = 1'b0;
    checkPins("R7 read leaves pins");

    // R7: data follows pins within a read
    @(negedge clk);
    en = 1'b1; rdStb = 1'b1; addr = INA; pinsIn = 8'h12;
    #0.5;
    chk(dataOut == 8'h12, "R7 follow 12", {8'h0, dataOut}, 16'h12);
    pinsIn = 8'hED;
    #0.5;
    chk(dataOut == 8'hED, "R7 follow ED", {8'h0, dataOut}, 16'hED);

    // R6: read disabled
    en = 1'b0;
    #0.5;
    chk(dataOe == 1'b0, "R6 read while disabled", {15'h0, dataOe}, 16'h0);

    // R5: read of output address does not drive
    en = 1'b1; addr = BASE;
    #0.5;
    chk(dataOe == 1'b0, "R5 read of base", {15'h0, dataOe}, 16'h0);
    rdStb = 1'b0; en = 1'b0;

    // R4: reads and writes together at their own addresses
    @(negedge clk);
    en = 1'b1; rdStb = 1'b1; wrStb = 1'b0; addr = INA; pinsIn = 8'h66;
    #1;
    chk(dataOe && dataOut == 8'h66, "R4 directed read", {8'h0, dataOut}, 16'h66);
    rdStb = 1'b0; en = 1'b0;
    busWrite(1'b1, BASE, 8'h00); expOut = 8'h00; checkPins("R2 write zero");
    busWrite(1'b1, BASE, 8'hFF); expOut = 8'hFF; checkPins("R2 write FF");

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule